// File: doc/BRIEF.md
# Command Queue Packet Decoder

This block sits between a ring-buffer command queue and the parameter register file of a 2D drawing engine. Fetch logic, outside this block, presents one 8-byte packet per beat on a 64-bit valid/ready stream. The block takes a packet only while its own read pointer differs from the write pointer that the queue producer publishes. It then classifies the header. A register-write packet carries its data word into one of sixteen parameter registers or into one of sixty-four pattern words. A null packet is absorbed without effect. Anything else is dropped and latches an error flag.

A write to the command register index raises a one-cycle start pulse toward the engine. While the engine reports that it is busy, a further command write is held off by keeping ready low. The host can also write the same registers directly through a byte-addressed write port. That path takes precedence over the queue in any cycle where both would write. The engine reads its parameters back through a combinational read port that uses the same index space as the packets.

Top module: `cq_pkt_decoder`

## Requirements
- R1: After reset, rd_ptr is 0, start_o and err_o are 0, and every parameter and pattern register reads 0.
- R2: pkt_ready is low whenever rd_ptr equals wr_ptr. Each accepted packet (pkt_valid and pkt_ready high at a clock edge) advances rd_ptr by one. rd_ptr holds when no packet is accepted.
- R3: rd_ptr counts 8-byte packets and wraps to 0 after 2^(15+ring_sel)-1, with ring_sel 0..4 selecting a ring of 256 KiB, 512 KiB, 1 MiB, 2 MiB or 4 MiB.
- R4: The header is pkt_data[31:0] and the data word is pkt_data[63:32]. A header with bits 15:0 equal to 0x9562 is a register write to the index in header bits 31:24. Indices 0x00..0x0F select the sixteen parameter registers. The written value reads back at prm_raddr equal to that index from the cycle after acceptance.
- R5: Indices 0x40..0x7F select pattern word n = index-0x40, for n from 0 to 63, read back at prm_raddr 0x40+n.
- R6: A packet whose header is exactly 0x00009561 is consumed (rd_ptr advances) and changes no register, start_o or err_o.
- R7: A packet with any other header code, or with a write index in 0x10..0x3F or 0x80..0xFF, is consumed and changes no register. err_o goes high in the next cycle and stays high until reset.
- R8: Accepting a write to index 0x0F drives start_o high for exactly the next cycle, in which register 0x0F already holds the new value.
- R9: A command-index write packet sees pkt_ready low while engine_busy or start_o is high. Other packets are not held off by engine_busy.
- R10: host_we writes host_wdata at byte offset host_addr. Offset 0x8000+4*i reaches parameter i (0..15), and 0x8100+4*n reaches pattern word n (0..63). A host write to 0x803C also raises start_o in the next cycle. Unaligned or unmapped offsets change nothing.
- R11: pkt_ready is low in every cycle in which host_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_sel | input | 3 | Ring size code, 0..4 for 256 KiB..4 MiB |
| wr_ptr | input | 19 | Producer write pointer in packet units |
| rd_ptr | output | 19 | Consumer read pointer in packet units |
| pkt_valid | input | 1 | Packet beat valid |
| pkt_data | input | 64 | Packet: header in 31:0, data in 63:32 |
| pkt_ready | output | 1 | Packet beat accepted when high with valid |
| host_we | input | 1 | Direct host register write strobe |
| host_addr | input | 16 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| engine_busy | input | 1 | Drawing engine still running |
| prm_raddr | input | 7 | Register read index (0x00..0x0F, 0x40..0x7F) |
| prm_rdata | output | 32 | Register read data, 0 for unmapped index |
| start_o | output | 1 | One-cycle launch pulse |
| err_o | output | 1 | Sticky malformed-packet flag |

## Verification
A wrong read pointer shows up on rd_ptr in the cycle after the bad step, and the ring-wrap scenario exposes a wrong mask at the exact packet where the ring closes. A wrongly decoded index lands data in a neighbouring register. That shows at the read port one cycle after acceptance, so each write is followed by readback of both the target and the registers a mis-decode would alias to. A broken stall or priority rule shows combinationally on pkt_ready in the same cycle, before any edge commits the packet.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

    localparam logic [15:0] WR_MAGIC    = 16'h9562;
    localparam logic [31:0] NULL_HEADER = 32'h0000_9561;
    localparam logic [6:0]  CMD_INDEX   = 7'h0F;
    localparam logic [6:0]  PAT_BASE    = 7'h40;
    localparam logic [15:0] HOST_BASE   = 16'h8000;
    localparam int          IDX_W       = 7;
    localparam int          WORD_W      = 32;

    typedef enum logic [1:0] {
        PK_WRITE = 2'd0,
        PK_NULL  = 2'd1,
        PK_BAD   = 2'd2
    } pkt_kind_e;

    // Index is mapped when it names a parameter or a pattern word
    function automatic logic idx_ok(input logic [IDX_W-1:0] idx,
                                    input int n_prm, input int n_pat);
        logic ok;
        ok = 1'b0;
        if (!idx[6] && (int'(idx) < n_prm))
            ok = 1'b1;
        if (idx[6] && (int'(idx[5:0]) < n_pat))
            ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/cqd_ring_ptr.sv
module cqd_ring_ptr #(
    parameter int MIN_LOG2 = 15,
    parameter int N_SIZES  = 5,
    parameter int PTR_W    = MIN_LOG2 + N_SIZES - 1,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ring_sel,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             advance,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             not_empty
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
    } ring_t;

    ring_t            st_d, st_q;
    logic [PTR_W-1:0] wrap_mask;
    int               size_log2;

    always_comb begin
        st_d = st_q;
        if (int'(ring_sel) > N_SIZES - 1)
            size_log2 = MIN_LOG2 + N_SIZES - 1;
        else
            size_log2 = MIN_LOG2 + int'(ring_sel);
        for (int b = 0; b < PTR_W; b++)
            wrap_mask[b] = (b < size_log2);
        if (advance)
            st_d.rd = (st_q.rd + 1'b1) & wrap_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_ptr    = st_q.rd;
    assign not_empty = (st_q.rd != wr_ptr);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(rd_ptr));

    p_rd_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (rd_ptr != $past(rd_ptr)));

endmodule

// File: rtl/cqd_hdr_dec.sv
module cqd_hdr_dec
    import cqd_pkg::*;
#(
    parameter int N_PRM = 16,
    parameter int N_PAT = 64
) (
    input  logic [WORD_W-1:0] header,
    output pkt_kind_e         kind,
    output logic [IDX_W-1:0]  widx,
    output logic              is_cmd
);

    logic [7:0] raw_idx;

    always_comb begin
        raw_idx = header[31:24];
        widx    = raw_idx[IDX_W-1:0];
        kind    = PK_BAD;
        if (header == NULL_HEADER)
            kind = PK_NULL;
        else if (header[15:0] == WR_MAGIC && !raw_idx[7]
                 && idx_ok(raw_idx[IDX_W-1:0], N_PRM, N_PAT))
            kind = PK_WRITE;
        is_cmd = (kind == PK_WRITE) && (widx == CMD_INDEX);
    end

endmodule

// File: rtl/cqd_host_dec.sv
module cqd_host_dec
    import cqd_pkg::*;
#(
    parameter int N_PRM = 16,
    parameter int N_PAT = 64
) (
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  widx
);

    logic [15:0] offs;

    always_comb begin
        offs = host_addr - HOST_BASE;
        // Offset 0x100 lands on index 0x40, so one slice serves both areas
        widx = offs[IDX_W+1:2];
        hit  = host_we && (offs[1:0] == 2'b00) && (offs < 16'h0200)
               && idx_ok(widx, N_PRM, N_PAT);
    end

endmodule

// File: rtl/cqd_regfile.sv
module cqd_regfile
    import cqd_pkg::*;
#(
    parameter int N_PRM = 16,
    parameter int N_PAT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int PRM_AW = (N_PRM > 1) ? $clog2(N_PRM) : 1;
    localparam int PAT_AW = (N_PAT > 1) ? $clog2(N_PAT) : 1;

    typedef struct packed {
        logic [N_PAT-1:0][WORD_W-1:0] pat;
        logic [N_PRM-1:0][WORD_W-1:0] prm;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            if (widx[6]) begin
                if (int'(widx[5:0]) < N_PAT)
                    rf_d.pat[widx[PAT_AW-1:0]] = wdata;
            end else if (int'(widx) < N_PRM) begin
                rf_d.prm[widx[PRM_AW-1:0]] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rf_q <= '0;
        else
            rf_q <= rf_d;
    end

    always_comb begin
        rdata = '0;
        if (raddr[6]) begin
            if (int'(raddr[5:0]) < N_PAT)
                rdata = rf_q.pat[raddr[PAT_AW-1:0]];
        end else if (int'(raddr) < N_PRM) begin
            rdata = rf_q.prm[raddr[PRM_AW-1:0]];
        end
    end

endmodule

// File: rtl/cq_pkt_decoder.sv
module cq_pkt_decoder
    import cqd_pkg::*;
#(
    parameter int MIN_RING_LOG2 = 15,
    parameter int N_RING_SIZES  = 5,
    parameter int N_PRM         = 16,
    parameter int N_PAT         = 64,
    parameter int PTR_W         = MIN_RING_LOG2 + N_RING_SIZES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ring_sel,
    input  logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    input  logic              pkt_valid,
    input  logic [63:0]       pkt_data,
    output logic              pkt_ready,
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              engine_busy,
    input  logic [6:0]        prm_raddr,
    output logic [31:0]       prm_rdata,
    output logic              start_o,
    output logic              err_o
);

    typedef struct packed {
        logic start;
        logic err;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    pkt_kind_e         q_kind;
    logic [IDX_W-1:0]  q_widx, h_widx, rf_widx;
    logic              q_is_cmd, h_hit, ring_has, accept, rf_we;
    logic [WORD_W-1:0] rf_wdata;

    cqd_ring_ptr #(
        .MIN_LOG2 (MIN_RING_LOG2),
        .N_SIZES  (N_RING_SIZES),
        .PTR_W    (PTR_W),
        .SEL_W    (3)
    ) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_sel  (ring_sel),
        .wr_ptr    (wr_ptr),
        .advance   (accept),
        .rd_ptr    (rd_ptr),
        .not_empty (ring_has)
    );

    cqd_hdr_dec #(.N_PRM(N_PRM), .N_PAT(N_PAT)) hdr_i (
        .header (pkt_data[31:0]),
        .kind   (q_kind),
        .widx   (q_widx),
        .is_cmd (q_is_cmd)
    );

    cqd_host_dec #(.N_PRM(N_PRM), .N_PAT(N_PAT)) host_i (
        .host_we   (host_we),
        .host_addr (host_addr),
        .hit       (h_hit),
        .widx      (h_widx)
    );

    always_comb begin
        ctl_d     = ctl_q;
        pkt_ready = ring_has && !host_we
                    && !(q_is_cmd && (engine_busy || ctl_q.start));
        accept    = pkt_valid && pkt_ready;
        if (host_we) begin
            rf_we    = h_hit;
            rf_widx  = h_widx;
            rf_wdata = host_wdata;
        end else begin
            rf_we    = accept && (q_kind == PK_WRITE);
            rf_widx  = q_widx;
            rf_wdata = pkt_data[63:32];
        end
        ctl_d.start = rf_we && (rf_widx == CMD_INDEX);
        if (accept && q_kind == PK_BAD)
            ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    cqd_regfile #(.N_PRM(N_PRM), .N_PAT(N_PAT)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .raddr (prm_raddr),
        .rdata (prm_rdata)
    );

    assign start_o = ctl_q.start;
    assign err_o   = ctl_q.err;

    p_no_take_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == wr_ptr) |-> !pkt_ready);

    p_host_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !pkt_ready);

    p_cmd_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_is_cmd && engine_busy) |-> !pkt_ready);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_null_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && q_kind == PK_NULL && !host_we) |=> !start_o);

endmodule

// File: tb/cq_pkt_decoder_tb_top.sv
module cq_pkt_decoder_tb_top;

    localparam int PTR_W = 19;
    localparam logic [31:0] NULL_H = 32'h0000_9561;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ring_sel = 3'd0;
    logic [PTR_W-1:0] wr_ptr = '0;
    logic [PTR_W-1:0] rd_ptr;
    logic             pkt_valid = 1'b0;
    logic [63:0]      pkt_data = '0;
    logic             pkt_ready;
    logic             host_we = 1'b0;
    logic [15:0]      host_addr = '0;
    logic [31:0]      host_wdata = '0;
    logic             engine_busy = 1'b0;
    logic [6:0]       prm_raddr = '0;
    logic [31:0]      prm_rdata;
    logic             start_o, err_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_rd = 0;

    always #5 clk = ~clk;

    cq_pkt_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ring_sel(ring_sel), .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .engine_busy(engine_busy),
        .prm_raddr(prm_raddr), .prm_rdata(prm_rdata),
        .start_o(start_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wr_hdr(input logic [7:0] idx);
        return {idx, 8'h00, 16'h9562};
    endfunction

    task automatic rd_reg(input logic [6:0] idx, output logic [31:0] val);
        prm_raddr = idx;
        #1;
        val = prm_rdata;
    endtask

    // Present one packet that must be taken; returns at the negedge after the edge
    task automatic push(input logic [31:0] hdr, input logic [31:0] dat, input string tag);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = {dat, hdr};
        #1 chk({tag, " ready"}, pkt_ready, 1'b1);
        @(posedge clk);
        exp_rd++;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        #1;
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 start_o", start_o, 0);
        chk("R1 err_o", err_o, 0);
        rd_reg(7'h03, v); chk("R1 prm3", v, 0);
        rd_reg(7'h45, v); chk("R1 pat5", v, 0);
    endtask

    task automatic t_empty_gate;
        @(negedge clk);
        wr_ptr = PTR_W'(exp_rd);
        pkt_valid = 1'b1;
        pkt_data = {32'h1, wr_hdr(8'h01)};
        #1 chk("R2 ready when empty", pkt_ready, 0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R2 rd held", rd_ptr, PTR_W'(exp_rd));
        pkt_valid = 1'b0;
        wr_ptr = 19'h40000;
        push(wr_hdr(8'h01), 32'h0000_0101, "R2");
        #1 chk("R2 rd step", rd_ptr, PTR_W'(exp_rd));
    endtask

    task automatic t_params;
        logic [31:0] v;
        for (int i = 0; i < 15; i++)
            push(wr_hdr(8'(i)), 32'hA500_0000 | 32'(i), "R4");
        for (int i = 0; i < 15; i++) begin
            rd_reg(7'(i), v);
            chk("R4 param readback", v, 32'hA500_0000 | 32'(i));
        end
        chk("R4 rd count", rd_ptr, PTR_W'(exp_rd));
        chk("R4 no start", start_o, 0);
    endtask

    task automatic t_pattern;
        logic [31:0] v;
        push(wr_hdr(8'h40), 32'h5A5A_0000, "R5");
        push(wr_hdr(8'h7F), 32'h5A5A_003F, "R5");
        rd_reg(7'h40, v); chk("R5 pat0", v, 32'h5A5A_0000);
        rd_reg(7'h7F, v); chk("R5 pat63", v, 32'h5A5A_003F);
        rd_reg(7'h41, v); chk("R5 pat1 untouched", v, 0);
        rd_reg(7'h00, v); chk("R5 prm0 untouched", v, 32'hA500_0000);
    endtask

    task automatic t_null;
        logic [31:0] v;
        push(NULL_H, 32'hFFFF_FFFF, "R6");
        #1;
        chk("R6 rd advanced", rd_ptr, PTR_W'(exp_rd));
        chk("R6 no err", err_o, 0);
        chk("R6 no start", start_o, 0);
        rd_reg(7'h00, v); chk("R6 prm0", v, 32'hA500_0000);
        rd_reg(7'h40, v); chk("R6 pat0", v, 32'h5A5A_0000);
        push(32'h0100_9561, 32'h0, "R7 near-null");
        #1 chk("R7 near-null err", err_o, 1);
    endtask

    task automatic t_cmd_start;
        logic [31:0] v;
        push(wr_hdr(8'h0F), 32'h0000_0001, "R8");
        #1 chk("R8 start high", start_o, 1);
        rd_reg(7'h0F, v); chk("R8 cmd value", v, 1);
        @(negedge clk);
        #1 chk("R8 start one cycle", start_o, 0);
    endtask

    task automatic t_busy_stall;
        logic [31:0] v;
        @(negedge clk);
        engine_busy = 1'b1;
        pkt_valid = 1'b1;
        pkt_data = {32'h2, wr_hdr(8'h0F)};
        #1 chk("R9 stall busy", pkt_ready, 0);
        @(posedge clk);
        @(negedge clk);
        #1 chk("R9 rd held", rd_ptr, PTR_W'(exp_rd));
        chk("R9 no start", start_o, 0);
        pkt_data = {32'h77, wr_hdr(8'h07)};
        #1 chk("R9 non-cmd passes", pkt_ready, 1);
        @(posedge clk);
        exp_rd++;
        @(negedge clk);
        engine_busy = 1'b0;
        pkt_data = {32'h3, wr_hdr(8'h0F)};
        #1 chk("R9 cmd after busy", pkt_ready, 1);
        @(posedge clk);
        exp_rd++;
        @(negedge clk);
        pkt_data = {32'h4, wr_hdr(8'h0F)};
        #1 chk("R9 start pulse", start_o, 1);
        chk("R9 stall on start", pkt_ready, 0);
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        #1;
        rd_reg(7'h07, v); chk("R9 fg", v, 32'h77);
        rd_reg(7'h0F, v); chk("R9 cmd", v, 3);
        chk("R9 rd", rd_ptr, PTR_W'(exp_rd));
    endtask

    task automatic t_host;
        logic [31:0] v;
        host_wr(16'h8008, 32'h1111_2222);
        rd_reg(7'h02, v); chk("R10 host prm2", v, 32'h1111_2222);
        host_wr(16'h81FC, 32'h3333_4444);
        rd_reg(7'h7F, v); chk("R10 host pat63", v, 32'h3333_4444);
        host_wr(16'h8040, 32'hBAD0_0001);
        host_wr(16'h8002, 32'hBAD0_0002);
        host_wr(16'h7FFC, 32'hBAD0_0003);
        rd_reg(7'h00, v); chk("R10 prm0 untouched", v, 32'hA500_0000);
        rd_reg(7'h40, v); chk("R10 pat0 untouched", v, 32'h5A5A_0000);
        rd_reg(7'h0F, v); chk("R10 prm15 untouched", v, 3);
        host_wr(16'h803C, 32'h0000_0009);
        #1 chk("R10 host start", start_o, 1);
        rd_reg(7'h0F, v); chk("R10 host cmd", v, 9);
    endtask

    task automatic t_host_prio;
        logic [31:0] v;
        @(negedge clk);
        host_we = 1'b1; host_addr = 16'h8004; host_wdata = 32'hC0DE_0001;
        pkt_valid = 1'b1; pkt_data = {32'hC0DE_0002, wr_hdr(8'h01)};
        #1 chk("R11 ready low", pkt_ready, 0);
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        rd_reg(7'h01, v); chk("R11 host landed", v, 32'hC0DE_0001);
        chk("R11 rd held", rd_ptr, PTR_W'(exp_rd));
        chk("R11 ready back", pkt_ready, 1);
        @(posedge clk);
        exp_rd++;
        @(negedge clk);
        pkt_valid = 1'b0;
        rd_reg(7'h01, v); chk("R11 packet after", v, 32'hC0DE_0002);
    endtask

    task automatic t_bad;
        logic [31:0] v;
        push(32'h0500_9563, 32'hDEAD_0001, "R7 magic");
        #1 chk("R7 err set", err_o, 1);
        chk("R7 consumed", rd_ptr, PTR_W'(exp_rd));
        rd_reg(7'h05, v); chk("R7 prm5 kept", v, 32'hA500_0005);
        push(wr_hdr(8'h20), 32'hDEAD_0002, "R7 gap idx");
        push(wr_hdr(8'h80), 32'hDEAD_0003, "R7 high idx");
        rd_reg(7'h00, v); chk("R7 prm0 kept", v, 32'hA500_0000);
        rd_reg(7'h60, v); chk("R7 pat32 kept", v, 0);
        rd_reg(7'h40, v); chk("R7 pat0 kept", v, 32'h5A5A_0000);
        push(wr_hdr(8'h0A), 32'h0000_00AA, "R7");
        #1 chk("R7 err sticky", err_o, 1);
        chk("R7 start quiet", start_o, 0);
    endtask

    task automatic t_wrap;
        int n;
        n = 32768 - exp_rd;
        @(negedge clk);
        ring_sel = 3'd0;
        pkt_valid = 1'b1;
        pkt_data = {32'h0, NULL_H};
        repeat (n) @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        #1 chk("R3 wrap 256K", rd_ptr, 0);
        @(negedge clk);
        ring_sel = 3'd1;
        pkt_valid = 1'b1;
        repeat (32768) @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        #1 chk("R3 no wrap 512K", rd_ptr, 19'h08000);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty_gate();
        t_params();
        t_pattern();
        t_cmd_start();
        t_busy_stall();
        t_host();
        t_host_prio();
        t_null();
        t_bad();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule